// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side command engine of a byte-addressed serial nonvolatile memory that talks SPI mode 0. It runs on a fast system clock. The four pins (chip select, serial clock, serial input and pause) pass through two-flop synchronisers, and the block acts on the edges it detects on them. Each transfer starts with an 8-bit opcode, taken MSB first on rising serial-clock edges. Six opcodes are decoded:

- 0x06 pulses the write-enable set line.
- 0x04 pulses the write-enable clear line.
- 0x05 streams the status byte without end.
- 0x01 hands one byte to the status interface.
- 0x03 takes a 16-bit address, then streams array data and steps the address after each byte.
- 0x02 takes a 16-bit address, then hands each following byte to a separate page-buffer block.

Read data leave on falling serial-clock edges. The serial output is driven only while data are being shifted out.

A surrounding protection block supplies the status byte, whose bit 0 is the busy flag. While that flag is set, every opcode except the status read is thrown away. Pulling the pause pin low freezes the sequence in place and releases the output. Raising chip select ends the transfer, releases the output and sends a one-cycle end pulse. The page buffer uses that pulse to start its write.

The states are: IDLE, OPC (opcode), AHI (address high byte), ALO (address low byte), READ, STAT, WDAT (array write data), SDAT (status write data) and SKIP. The transitions are:

- Any state goes to IDLE while chip select is high.
- IDLE goes to OPC on a chip-select fall.
- OPC goes to STAT on 0x05.
- OPC goes to SDAT on 0x01.
- OPC goes to AHI on 0x03 or 0x02.
- OPC goes to SKIP on any other opcode, including 0x06 and 0x04, or when busy blocks the opcode.
- AHI goes to ALO.
- ALO goes to READ or WDAT, depending on the opcode.
- SDAT goes to SKIP after its one byte.
- READ, STAT, WDAT and SKIP hold until chip select rises.

Top module: `sermem_front`

## Requirements
- R1: SI is captured on rising SCK edges and SO changes only after falling SCK edges. Every byte goes out MSB first.
- R2: Opcode 0x06 gives exactly one `wen_set` pulse. Opcode 0x04 gives exactly one `wen_clr` pulse. No two of the five strobe outputs are ever high together.
- R3: A command is decoded only after a falling edge on `cs_n_pin`, so clocking with chip select high has no effect. Raising chip select releases SO (`so_oe`=0) and gives one `xfer_end` pulse.
- R4: Opcodes 0x03 and 0x02 take a 16-bit address, high byte first. Only the low AW bits are used (default 13), so the upper bits are ignored.
- R5: A read returns `mem_rd_data` for the address, then for address+1 after each byte, wrapping from 2^AW-1 to 0.
- R6: For opcode 0x02, one `wr_addr_valid` pulse carries the address. Each later complete byte gives one `wr_data_valid` pulse carrying that byte.
- R7: Opcode 0x05 shifts out `stat_in`. A new copy of `stat_in` is taken for every further byte while clocks continue.
- R8: Opcode 0x01 passes the first following byte on one `stat_wr_valid` pulse. Any further bytes are ignored.
- R9: While `stat_in[0]` (busy) is 1, any opcode other than 0x05 discards the transfer. No strobe fires, no read is issued and SO stays released.
- R10: An unknown opcode makes the rest of the transfer ignored until chip select rises.
- R11: While `hold_n_pin` is low with chip select low, SO is released and SCK and SI are ignored. After release the transfer resumes at the same bit.
- R12: After reset SO is released and no strobe has fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, much faster than SCK |
| rst_n | input | 1 | active-low reset |
| cs_n_pin | input | 1 | chip select, active low |
| sck_pin | input | 1 | serial clock |
| si_pin | input | 1 | serial data in |
| hold_n_pin | input | 1 | pause, active low |
| so_data | output | 1 | serial data out value |
| so_oe | output | 1 | serial data out drive enable |
| mem_rd_en | output | 1 | array read request |
| mem_rd_addr | output | AW | array read address |
| mem_rd_data | input | 8 | array data, valid one cycle after request |
| stat_in | input | 8 | status byte, bit 0 = busy |
| wen_set | output | 1 | write-enable set pulse |
| wen_clr | output | 1 | write-enable clear pulse |
| stat_wr_valid | output | 1 | status write pulse |
| stat_wr_data | output | 8 | status write byte |
| wr_addr_valid | output | 1 | page-buffer start address pulse |
| wr_addr | output | AW | page-buffer start address |
| wr_data_valid | output | 1 | page-buffer data byte pulse |
| wr_data | output | 8 | page-buffer data byte |
| xfer_end | output | 1 | chip-select rise pulse |

## Verification
A pin edge reaches the decode logic three system clocks later. That is two synchroniser flops plus the edge register. Strobes and SO updates are registered at that point, and read data arrive one to two cycles after that.

The bench holds each SCK phase for six system clocks. It samples SO and `so_oe` six clocks after the preceding falling edge, just before the next rising edge, so every result is settled.

Strobe pulses are counted by a monitor on every clock. Those counts and the captured bytes are compared only after chip select has been raised, by which point all strobes of the transfer have fired.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_READ,
        ST_STAT, ST_WDAT, ST_SDAT, ST_SKIP
    } st_e;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_WR    = 8'h02;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] s1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1[g]  <= RV[g];
                q[g]   <= RV[g];
                q_d[g] <= RV[g];
            end else begin
                s1[g]  <= d[g];
                q[g]   <= s1[g];
                q_d[g] <= q[g];
            end
        end
    end
endmodule

// File: rtl/sermem_bitrx.sv
module sermem_bitrx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       step,
    input  logic       din,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] bitcnt
);
    logic [6:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            bitcnt <= '0;
        end else if (restart) begin
            bitcnt <= '0;
        end else if (step) begin
            sh     <= {sh[5:0], din};
            bitcnt <= bitcnt + 3'd1;
        end
    end

    assign byte_done = step && !restart && (bitcnt == 3'd7);
    assign byte_val  = {sh, din};
endmodule

// File: rtl/sermem_bittx.sv
module sermem_bittx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic [7:0] ld_val,
    input  logic       shift,
    output logic       so,
    output logic       on
);
    logic [7:0] obyte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obyte <= '0;
            so    <= 1'b0;
            on    <= 1'b0;
        end else if (clear) begin
            on <= 1'b0;
        end else if (load) begin
            obyte <= ld_val;
        end else if (shift) begin
            so    <= obyte[7];
            obyte <= {obyte[6:0], 1'b0};
            on    <= 1'b1;
        end
    end
endmodule

// File: rtl/sermem_front.sv
module sermem_front
    import sermem_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_pin,
    input  logic          sck_pin,
    input  logic          si_pin,
    input  logic          hold_n_pin,
    output logic          so_data,
    output logic          so_oe,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    input  logic [7:0]    stat_in,
    output logic          wen_set,
    output logic          wen_clr,
    output logic          stat_wr_valid,
    output logic [7:0]    stat_wr_data,
    output logic          wr_addr_valid,
    output logic [AW-1:0] wr_addr,
    output logic          wr_data_valid,
    output logic [7:0]    wr_data,
    output logic          xfer_end
);
    localparam int HW = AW - 8;

    logic [3:0] pin_s, pin_d;
    logic cs_s, cs_d, sck_s, sck_d, si_s, hold_s;
    logic held, busy, act, step, sck_fall;
    logic byte_done, rd_pend, is_rd, tx_on, tx_load, stat_load;
    logic [7:0] byte_val, ld_val;
    logic [2:0] bitcnt;
    logic [HW-1:0] addr_hi;
    logic [AW-1:0] full_addr;
    st_e st, st_nx;

    sermem_sync #(.W(4), .RV(4'b1001)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hold_n_pin, si_pin, sck_pin, cs_n_pin}),
        .q(pin_s), .q_d(pin_d)
    );

    assign cs_s   = pin_s[0];
    assign cs_d   = pin_d[0];
    assign sck_s  = pin_s[1];
    assign sck_d  = pin_d[1];
    assign si_s   = pin_s[2];
    assign hold_s = pin_s[3];

    assign held     = !hold_s && !cs_s;
    assign busy     = stat_in[0];
    assign act      = !cs_s && !held && (st != ST_IDLE);
    assign step     = sck_s && !sck_d && act;
    assign sck_fall = !sck_s && sck_d;

    sermem_bitrx i_rx (
        .clk(clk), .rst_n(rst_n), .restart(cs_s), .step(step), .din(si_s),
        .byte_done(byte_done), .byte_val(byte_val), .bitcnt(bitcnt)
    );

    assign stat_load = byte_done &&
        ((st == ST_OPC && !busy && byte_val == OP_RSTAT) ||
         (st == ST_OPC && busy && byte_val == OP_RSTAT) ||
         (st == ST_STAT));
    assign tx_load = rd_pend || stat_load;
    assign ld_val  = rd_pend ? mem_rd_data : stat_in;

    sermem_bittx i_tx (
        .clk(clk), .rst_n(rst_n), .clear(cs_s), .load(tx_load), .ld_val(ld_val),
        .shift(sck_fall && act && (st == ST_READ || st == ST_STAT)),
        .so(so_data), .on(tx_on)
    );

    assign so_oe     = tx_on && !held && !cs_s;
    assign full_addr = {addr_hi, byte_val};

    // next state
    always_comb begin
        st_nx = st;
        if (cs_s) begin
            st_nx = ST_IDLE;
        end else if (st == ST_IDLE) begin
            if (cs_d) st_nx = ST_OPC;
        end else if (byte_done) begin
            unique case (st)
                ST_OPC: begin
                    if (busy && byte_val != OP_RSTAT) st_nx = ST_SKIP;
                    else if (byte_val == OP_RSTAT) st_nx = ST_STAT;
                    else if (byte_val == OP_WSTAT) st_nx = ST_SDAT;
                    else if (byte_val == OP_RD || byte_val == OP_WR) st_nx = ST_AHI;
                    else st_nx = ST_SKIP;
                end
                ST_AHI:  st_nx = ST_ALO;
                ST_ALO:  st_nx = is_rd ? ST_READ : ST_WDAT;
                ST_SDAT: st_nx = ST_SKIP;
                ST_IDLE, ST_READ, ST_STAT, ST_WDAT, ST_SKIP: st_nx = st;
                default: st_nx = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_set <= 1'b0; wen_clr <= 1'b0;
            stat_wr_valid <= 1'b0; stat_wr_data <= '0;
            wr_addr_valid <= 1'b0; wr_addr <= '0;
            wr_data_valid <= 1'b0; wr_data <= '0;
            mem_rd_en <= 1'b0; mem_rd_addr <= '0;
            rd_pend <= 1'b0; is_rd <= 1'b0; addr_hi <= '0;
            xfer_end <= 1'b0;
        end else begin
            wen_set       <= 1'b0;
            wen_clr       <= 1'b0;
            stat_wr_valid <= 1'b0;
            wr_addr_valid <= 1'b0;
            wr_data_valid <= 1'b0;
            mem_rd_en     <= 1'b0;
            rd_pend       <= mem_rd_en;
            xfer_end      <= cs_s && !cs_d;
            if (byte_done) begin
                unique case (st)
                    ST_OPC: begin
                        is_rd   <= (byte_val == OP_RD);
                        wen_set <= !busy && byte_val == OP_WEN;
                        wen_clr <= !busy && byte_val == OP_WDIS;
                    end
                    ST_AHI: addr_hi <= byte_val[HW-1:0];
                    ST_ALO: begin
                        if (is_rd) begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= full_addr;
                        end else begin
                            wr_addr_valid <= 1'b1;
                            wr_addr       <= full_addr;
                        end
                    end
                    ST_READ: begin
                        mem_rd_en   <= 1'b1;
                        mem_rd_addr <= mem_rd_addr + AW'(1);
                    end
                    ST_WDAT: begin
                        wr_data_valid <= 1'b1;
                        wr_data       <= byte_val;
                    end
                    ST_SDAT: begin
                        stat_wr_valid <= 1'b1;
                        stat_wr_data  <= byte_val;
                    end
                    ST_IDLE, ST_STAT, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

    // R3: chip select high releases the output on the next cycle
    p_oe_off_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe);

    // R11: a pause keeps the bit position
    p_hold_keeps_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> (bitcnt == $past(bitcnt)));

    // R2: strobes never overlap
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wen_set, wen_clr, stat_wr_valid, wr_addr_valid, wr_data_valid}));

    // R9: a busy opcode other than the status read leads to SKIP
    p_busy_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_OPC && busy && byte_val != OP_RSTAT)
            |=> (st == ST_SKIP || st == ST_IDLE));

    // R1: SO only moves after a falling SCK edge
    p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_data));
endmodule

// File: tb/test_sermem_front.sv
module test_sermem_front;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [7:0] stat = 8'h00, mrd = 8'h00;
    logic so_data, so_oe, mem_rd_en, wen_set, wen_clr, stat_wr_valid;
    logic wr_addr_valid, wr_data_valid, xfer_end;
    logic [12:0] mem_rd_addr, wr_addr;
    logic [7:0] stat_wr_data, wr_data;

    int total = 0, bad = 0;
    int n_set = 0, n_clr = 0, n_sw = 0, n_wa = 0, n_wd = 0, n_end = 0, n_rd = 0;
    logic [7:0] last_sw, wbuf[16];
    logic [12:0] last_wa;
    logic oe_all;

    always #4 clk = ~clk;

    sermem_front #(.AW(13)) i_sermem_front (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
        .hold_n_pin(hold_n), .so_data(so_data), .so_oe(so_oe),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mrd),
        .stat_in(stat), .wen_set(wen_set), .wen_clr(wen_clr),
        .stat_wr_valid(stat_wr_valid), .stat_wr_data(stat_wr_data),
        .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr),
        .wr_data_valid(wr_data_valid), .wr_data(wr_data), .xfer_end(xfer_end)
    );

    function automatic logic [7:0] mval(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    always @(posedge clk) begin
        mrd <= mval(mem_rd_addr);
        if (mem_rd_en) n_rd++;
        if (wen_set) n_set++;
        if (wen_clr) n_clr++;
        if (stat_wr_valid) begin n_sw++; last_sw = stat_wr_data; end
        if (wr_addr_valid) begin n_wa++; last_wa = wr_addr; end
        if (wr_data_valid) begin wbuf[n_wd % 16] = wr_data; n_wd++; end
        if (xfer_end) n_end++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        si = b;
        tick(3);
        r = so_data;
        oe_all = oe_all & so_oe;
        sck = 1'b1;
        tick(6);
        sck = 1'b0;
        tick(3);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        tick(3);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic do_read(input logic [15:0] a, input int len, input string tag);
        logic [7:0] rx;
        sel();
        xbyte(8'h03, rx);
        xbyte(a[15:8], rx);
        xbyte(a[7:0], rx);
        for (int k = 0; k < len; k++) begin
            xbyte(8'h00, rx);
            chk(tag, rx, mval(a[12:0] + 13'(k)));
            if (k == 0) chk({tag, " oe"}, oe_all, 1);
        end
        desel();
        chk("R3 so_oe released", so_oe, 0);
    endtask

    initial begin : wd
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rx;
        logic r;
        int s0;
        void'($urandom(32'd1234));
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R12 so_oe after reset", so_oe, 0);
        chk("R12 no strobes", n_set + n_clr + n_sw + n_wa + n_wd, 0);

        // R3: clocking with chip select high is ignored
        xbyte(8'h06, rx);
        tick(4);
        chk("R3 no decode without cs", n_set, 0);

        // R2
        sel(); xbyte(8'h06, rx); desel();
        chk("R2 wen_set", n_set, 1);
        chk("R3 xfer_end", n_end, 1);
        sel(); xbyte(8'h04, rx); desel();
        chk("R2 wen_clr", n_clr, 1);
        chk("R2 no extra set", n_set, 1);

        // R7 status repeated, resampled per byte
        stat = 8'hA4;
        sel(); xbyte(8'h05, rx);
        stat = 8'h3C;
        xbyte(8'h00, rx); chk("R7 status byte 1", rx, 8'hA4);
        chk("R1 status oe", oe_all, 1);
        xbyte(8'h00, rx); chk("R7 status byte 2", rx, 8'h3C);
        desel();
        chk("R3 so_oe after status", so_oe, 0);
        stat = 8'h00;

        // R5 / R1 reads
        do_read(16'h0123, 3, "R5 R1 read");
        do_read(16'hFFFF, 3, "R4 R5 wrap");

        // R6 / R4 write
        s0 = n_wd;
        sel(); xbyte(8'h02, rx); xbyte(8'hE0, rx); xbyte(8'h45, rx);
        xbyte(8'h11, rx); xbyte(8'h22, rx); xbyte(8'h33, rx); desel();
        chk("R4 R6 write addr", last_wa, 13'h0045);
        chk("R6 write count", n_wd - s0, 3);
        chk("R6 byte 0", wbuf[s0 % 16], 8'h11);
        chk("R6 byte 2", wbuf[(s0 + 2) % 16], 8'h33);

        // R8
        sel(); xbyte(8'h01, rx); xbyte(8'h8C, rx); xbyte(8'h55, rx); desel();
        chk("R8 status write count", n_sw, 1);
        chk("R8 status write data", last_sw, 8'h8C);

        // R9 busy
        stat = 8'h01;
        s0 = n_rd;
        sel(); xbyte(8'h06, rx); desel();
        chk("R9 busy blocks wren", n_set, 1);
        sel(); xbyte(8'h03, rx); xbyte(8'h00, rx); xbyte(8'h10, rx);
        xbyte(8'h00, rx); chk("R9 busy read no drive", oe_all, 0);
        desel();
        chk("R9 busy no array read", n_rd - s0, 0);
        sel(); xbyte(8'h05, rx); xbyte(8'h00, rx); desel();
        chk("R9 status read while busy", rx, 8'h01);
        stat = 8'h00;

        // R10 unknown opcode
        s0 = n_wa;
        sel(); xbyte(8'hAB, rx); xbyte(8'h06, rx); xbyte(8'h02, rx);
        xbyte(8'h00, rx); xbyte(8'h00, rx); desel();
        chk("R10 no wen after unknown", n_set, 1);
        chk("R10 no write after unknown", n_wa - s0, 0);
        chk("R10 no drive", oe_all, 0);

        // R11 pause mid-byte
        sel(); xbyte(8'h03, rx); xbyte(8'h00, rx); xbyte(8'h20, rx);
        oe_all = 1'b1;
        for (int i = 7; i >= 5; i--) begin sbit(1'b0, r); rx[i] = r; end
        hold_n = 1'b0;
        tick(5);
        chk("R11 released during pause", so_oe, 0);
        for (int j = 0; j < 4; j++) begin
            si = 1'($urandom);
            sck = 1'b1; tick(6); sck = 1'b0; tick(6);
        end
        chk("R11 still released", so_oe, 0);
        hold_n = 1'b1;
        tick(5);
        for (int i = 4; i >= 0; i--) begin sbit(1'b0, r); rx[i] = r; end
        chk("R11 byte across pause", rx, mval(13'h0020));
        xbyte(8'h00, rx);
        chk("R11 next byte", rx, mval(13'h0021));
        desel();

        // random mix
        for (int it = 0; it < 24; it++) begin
            if ($urandom % 2 == 0) begin
                do_read(16'($urandom), 1 + int'($urandom % 4), "R5 random read");
            end else begin
                stat = 8'($urandom);
                sel(); xbyte(8'h05, rx);
                xbyte(8'h00, rx); chk("R7 random status", rx, stat);
                xbyte(8'h00, rx); chk("R7 random status rep", rx, stat);
                desel();
                stat = 8'h00;
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule